// File: doc/BRIEF.md
# SPI Master with Per-Frame Chip-Select Queue

This block is an SPI master whose transmit queue holds more than data. Each queued command carries an 8-bit byte, a five-line chip-select pattern, a continue flag and an end-of-queue marker. The controller takes entries from the queue in order and shifts each byte out in SPI mode 0. While a frame is on the wire it drives the chip-select lines from that frame's own pattern, and it stores the byte clocked in on `miso` in a receive queue. Software decides in advance, frame by frame, when a chip select drops. Between frames it never has to toggle a pin.

Software reaches the block through a small register port with four word addresses:

| Address | Name | Behaviour |
|---|---|---|
| 0 | control | enable, clock divider, inactive level of each chip-select line, two self-clearing flush strobes |
| 1 | status | busy, both fill counts, a sticky end-of-queue flag and a sticky overflow flag; both flags are cleared by writing 1 |
| 2 | push | a write queues one transmit command |
| 3 | pop | a read returns the oldest received byte and removes it |

The shift engine is a five-state machine:

| State | SCK | Role |
|---|---|---|
| `ENG_IDLE` | low | chip selects released |
| `ENG_LOW` | low | the bit on `mosi` is set up |
| `ENG_HIGH` | high | `miso` was sampled on the rising edge that entered this state |
| `ENG_TAIL` | low | one low half period that closes the frame |
| `ENG_HOLD` | low | chip selects stay asserted while the engine waits for the next frame |

Each state lasts `DIV+1` system clocks. Its transitions:

- Launch: `ENG_IDLE`→`ENG_LOW` and `ENG_HOLD`→`ENG_LOW`, taken when the block is enabled and the transmit queue is not empty. The head entry is popped in the same cycle.
- Rise: `ENG_LOW`→`ENG_HIGH`.
- Next bit: `ENG_HIGH`→`ENG_LOW`, taken after bits 0 to 6.
- Last bit: `ENG_HIGH`→`ENG_TAIL`, taken after bit 7.
- Release: `ENG_TAIL`→`ENG_IDLE`, taken when the frame's continue flag is clear.
- Keep: `ENG_TAIL`→`ENG_HOLD`, taken when the frame's continue flag is set.
- Abort: any state→`ENG_IDLE`, taken on a transmit flush.

Top module: `spi_csq_master`

## Requirements
- R1: After reset, `cs_o` equals 5'h1F and `sck` is low. Status reads 0. Control reads 32'h001F_0300: enable 0, divider 3, inactive levels 5'h1F.
- R2: A push word carries the data byte in bits [7:0]. Bits [20:16] give the chip-select pattern, bit 30 the continue flag and bit 29 the end-of-queue marker. Frames go out in push order, each byte MSB first on `mosi`.
- R3: While a frame shifts, each line of `cs_o` is the inverse of its inactive level when the frame's pattern bit for that line is 1. Otherwise the line sits at its inactive level. Any combination of the five lines can be selected.
- R4: After a frame with the continue flag set, the chip selects stay asserted and the status busy bit (bit 0) stays 1 until a further frame launches. After a frame with the flag clear, `cs_o` returns to the inactive levels and busy reads 0.
- R5: The transmit queue holds 4 entries, and its fill count reads in status [15:12]. A push to a full queue is dropped, and it sets the sticky overflow flag at status bit 17.
- R6: Status bit 16 sets when a frame marked end-of-queue completes. It stays set until a status write with bit 16 = 1, which clears it.
- R7: Every frame puts one received byte, sampled MSB first on the rising edges of `sck`, into a 4-entry receive queue. Its fill count reads in status [7:4], and a read of address 3 returns the bytes in order.
- R8: A control write with bit 1 = 1 empties the transmit queue and stops any frame. A control write with bit 2 = 1 empties the receive queue. Both strobe bits read back 0.
- R9: Control bits [20:16] set the inactive level of each chip-select line, and `cs_o` shows those levels while the block is idle.
- R10: `sck` idles low and is high only inside a frame. Its period is 2×(DIV+1) system clocks, where DIV is control bits [15:8].
- R11: While control bit 0 (enable) is 0, no frame launches: `sck` stays low and queued entries remain queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a read of address 3 pops the receive queue) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| sck | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 5 | Chip-select lines |

## Verification
A frame launches on the first clock edge after the push is written. `sck` first rises `DIV+1` cycles after that edge. The received byte and the end-of-queue flag appear `17×(DIV+1)` cycles after launch, which is 35 cycles after the push edge at DIV=1. Flushes and flag clears act on the clock edge of the write itself. The bench does not count those delays with fixed waits. A slave model compares each byte and its chip-select pattern at the eighth rising `sck` edge of the frame. Status checks poll the fill count until the expected number of bytes is present, and the bench reads the chip-select lines only after that point or a few cycles later. Clock period is measured between consecutive rising `sck` edges inside one frame.

// File: rtl/spi_csq_pkg.sv
package spi_csq_pkg;

    localparam int CS_LINES = 5;
    localparam int BYTE_W   = 8;

    // register word addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_PUSH = 2'd2;
    localparam logic [1:0] ADDR_POP  = 2'd3;

    // push word fields
    localparam int PUSH_SEL_LSB = 16;
    localparam int PUSH_EOQ_BIT = 29;
    localparam int PUSH_CNT_BIT = 30;

    // control fields
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_FLTX_BIT = 1;
    localparam int CTRL_FLRX_BIT = 2;
    localparam int CTRL_DIV_LSB  = 8;
    localparam int CTRL_IDL_LSB  = 16;

    // status fields
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_RXC_LSB  = 4;
    localparam int STAT_TXC_LSB  = 12;
    localparam int STAT_EOQ_BIT  = 16;
    localparam int STAT_OVF_BIT  = 17;

    typedef struct packed {
        logic                cont;
        logic                eoq;
        logic [CS_LINES-1:0] sel;
        logic [BYTE_W-1:0]   data;
    } txq_entry_t;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH,
        ENG_TAIL,
        ENG_HOLD
    } eng_state_t;

endpackage

// File: rtl/spi_csq_fifo.sv
module spi_csq_fifo #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= ptr_step(wptr);
            if (do_pop)  rptr <= ptr_step(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wptr] <= wdata;
    end

endmodule

// File: rtl/spi_csq_engine.sv
module spi_csq_engine
    import spi_csq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                abort,
    input  logic [DIV_W-1:0]    div,
    input  logic                q_empty,
    input  txq_entry_t          q_head,
    output logic                q_pop,
    input  logic                miso,
    output logic                sck,
    output logic                mosi,
    output logic [CS_LINES-1:0] sel_active,
    output logic                busy,
    output logic                done,
    output logic                done_eoq,
    output logic [BYTE_W-1:0]   rx_byte
);

    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    eng_state_t          state;
    eng_state_t          nxt;
    logic [DIV_W-1:0]    tmr;
    logic                tmr_zero;
    logic [2:0]          bitc;
    logic [BYTE_W-1:0]   txsh;
    logic [BYTE_W-1:0]   rxsh;
    logic [CS_LINES-1:0] sel_q;
    logic                cur_cont;
    logic                cur_eoq;
    logic                launch;

    assign tmr_zero = (tmr == '0);
    assign launch   = !abort && enable && !q_empty &&
                      ((state == ENG_IDLE) || (state == ENG_HOLD));

    // next state
    always_comb begin
        nxt  = state;
        done = 1'b0;
        if (abort) begin
            nxt = ENG_IDLE;
        end else begin
            unique case (state)
                ENG_IDLE: if (launch) nxt = ENG_LOW;
                ENG_LOW:  if (tmr_zero) nxt = ENG_HIGH;
                ENG_HIGH: if (tmr_zero) nxt = (bitc == LAST_BIT) ? ENG_TAIL : ENG_LOW;
                ENG_TAIL: if (tmr_zero) begin
                    done = 1'b1;
                    nxt  = cur_cont ? ENG_HOLD : ENG_IDLE;
                end
                ENG_HOLD: if (launch) nxt = ENG_LOW;
                default:  nxt = ENG_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck      <= 1'b0;
            tmr      <= '0;
            bitc     <= '0;
            txsh     <= '0;
            rxsh     <= '0;
            sel_q    <= '0;
            cur_cont <= 1'b0;
            cur_eoq  <= 1'b0;
        end else if (abort) begin
            sck   <= 1'b0;
            tmr   <= '0;
            bitc  <= '0;
            sel_q <= '0;
        end else if (launch) begin
            sck      <= 1'b0;
            tmr      <= div;
            bitc     <= '0;
            txsh     <= q_head.data;
            sel_q    <= q_head.sel;
            cur_cont <= q_head.cont;
            cur_eoq  <= q_head.eoq;
        end else begin
            unique case (state)
                ENG_LOW: begin
                    if (tmr_zero) begin
                        sck  <= 1'b1;
                        rxsh <= {rxsh[BYTE_W-2:0], miso};
                        tmr  <= div;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ENG_HIGH: begin
                    if (tmr_zero) begin
                        sck <= 1'b0;
                        tmr <= div;
                        if (bitc != LAST_BIT) begin
                            txsh <= {txsh[BYTE_W-2:0], 1'b0};
                            bitc <= bitc + 1'b1;
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ENG_TAIL: begin
                    if (tmr_zero) begin
                        if (!cur_cont) sel_q <= '0;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign q_pop      = launch;
    assign mosi       = txsh[BYTE_W-1];
    assign sel_active = sel_q;
    assign busy       = (state != ENG_IDLE);
    assign done_eoq   = done && cur_eoq;
    assign rx_byte    = rxsh;

endmodule

// File: rtl/spi_csq_regs.sv
module spi_csq_regs
    import spi_csq_pkg::*;
#(
    parameter  int             DEPTH   = 4,
    parameter  int             DIV_W   = 8,
    parameter  logic [DIV_W-1:0] DIV_RST = 3,
    localparam int             CW      = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic                reg_re,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                enable,
    output logic [DIV_W-1:0]    div,
    output logic [CS_LINES-1:0] idle_lvl,
    output logic                flush_tx,
    output logic                flush_rx,
    output logic                push_req,
    output txq_entry_t          push_entry,
    output logic                pop_req,
    input  logic [CW-1:0]       tx_count,
    input  logic                tx_full,
    input  logic [CW-1:0]       rx_count,
    input  logic [BYTE_W-1:0]   rx_head,
    input  logic                rx_empty,
    input  logic                busy,
    input  logic                done_eoq,
    output logic                eoq_flag,
    output logic                ovf_flag
);

    logic wr_ctrl;
    logic wr_stat;
    logic unused_wbits;

    assign wr_ctrl  = reg_we && (reg_addr == ADDR_CTRL);
    assign wr_stat  = reg_we && (reg_addr == ADDR_STAT);
    assign push_req = reg_we && (reg_addr == ADDR_PUSH);
    assign pop_req  = reg_re && (reg_addr == ADDR_POP);
    assign flush_tx = wr_ctrl && reg_wdata[CTRL_FLTX_BIT];
    assign flush_rx = wr_ctrl && reg_wdata[CTRL_FLRX_BIT];

    assign push_entry.data = reg_wdata[BYTE_W-1:0];
    assign push_entry.sel  = reg_wdata[PUSH_SEL_LSB +: CS_LINES];
    assign push_entry.eoq  = reg_wdata[PUSH_EOQ_BIT];
    assign push_entry.cont = reg_wdata[PUSH_CNT_BIT];

    assign unused_wbits = ^{reg_wdata[31], reg_wdata[28:21], reg_wdata[15:8],
                            reg_wdata[7:3]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            div      <= DIV_RST;
            idle_lvl <= '1;
        end else if (wr_ctrl) begin
            enable   <= reg_wdata[CTRL_EN_BIT];
            div      <= reg_wdata[CTRL_DIV_LSB +: DIV_W];
            idle_lvl <= reg_wdata[CTRL_IDL_LSB +: CS_LINES];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoq_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (done_eoq)
                eoq_flag <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_EOQ_BIT])
                eoq_flag <= 1'b0;
            if (push_req && tx_full)
                ovf_flag <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_OVF_BIT])
                ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_EN_BIT]                = enable;
                reg_rdata[CTRL_DIV_LSB +: DIV_W]      = div;
                reg_rdata[CTRL_IDL_LSB +: CS_LINES]   = idle_lvl;
            end
            ADDR_STAT: begin
                reg_rdata[STAT_BUSY_BIT]       = busy;
                reg_rdata[STAT_RXC_LSB +: 4]   = 4'(rx_count);
                reg_rdata[STAT_TXC_LSB +: 4]   = 4'(tx_count);
                reg_rdata[STAT_EOQ_BIT]        = eoq_flag;
                reg_rdata[STAT_OVF_BIT]        = ovf_flag;
            end
            ADDR_POP: begin
                if (!rx_empty) reg_rdata[BYTE_W-1:0] = rx_head;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_csq_master.sv
module spi_csq_master
    import spi_csq_pkg::*;
#(
    parameter  int               QDEPTH  = 4,
    parameter  int               DIV_W   = 8,
    parameter  logic [DIV_W-1:0] DIV_RST = 3,
    localparam int               CW      = $clog2(QDEPTH + 1),
    localparam int               EW      = $bits(txq_entry_t)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [4:0]  cs_o
);

    logic                enable;
    logic [DIV_W-1:0]    div;
    logic [CS_LINES-1:0] idle_lvl;
    logic                flush_tx;
    logic                flush_rx;
    logic                push_req;
    txq_entry_t          push_entry;
    logic                pop_req;
    logic [CW-1:0]       tx_count;
    logic                tx_full;
    logic                tx_empty;
    logic [EW-1:0]       tx_head_bits;
    txq_entry_t          tx_head;
    logic                tx_pop;
    logic [CW-1:0]       rx_count;
    logic                rx_full;
    logic                rx_empty;
    logic [BYTE_W-1:0]   rx_head;
    logic                busy;
    logic                done;
    logic                done_eoq;
    logic [BYTE_W-1:0]   rx_byte;
    logic [CS_LINES-1:0] sel_active;
    logic                eoq_flag;
    logic                ovf_flag;
    logic                unused_rx_full;

    assign tx_head        = txq_entry_t'(tx_head_bits);
    assign cs_o           = idle_lvl ^ sel_active;
    assign unused_rx_full = rx_full;

    spi_csq_regs #(
        .DEPTH   (QDEPTH),
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .enable     (enable),
        .div        (div),
        .idle_lvl   (idle_lvl),
        .flush_tx   (flush_tx),
        .flush_rx   (flush_rx),
        .push_req   (push_req),
        .push_entry (push_entry),
        .pop_req    (pop_req),
        .tx_count   (tx_count),
        .tx_full    (tx_full),
        .rx_count   (rx_count),
        .rx_head    (rx_head),
        .rx_empty   (rx_empty),
        .busy       (busy),
        .done_eoq   (done_eoq),
        .eoq_flag   (eoq_flag),
        .ovf_flag   (ovf_flag)
    );

    spi_csq_fifo #(
        .WIDTH (EW),
        .DEPTH (QDEPTH)
    ) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_tx),
        .push  (push_req),
        .wdata (push_entry),
        .pop   (tx_pop),
        .rdata (tx_head_bits),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_csq_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (QDEPTH)
    ) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_rx),
        .push  (done),
        .wdata (rx_byte),
        .pop   (pop_req),
        .rdata (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_csq_engine #(
        .DIV_W (DIV_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .abort      (flush_tx),
        .div        (div),
        .q_empty    (tx_empty),
        .q_head     (tx_head),
        .q_pop      (tx_pop),
        .miso       (miso),
        .sck        (sck),
        .mosi       (mosi),
        .sel_active (sel_active),
        .busy       (busy),
        .done       (done),
        .done_eoq   (done_eoq),
        .rx_byte    (rx_byte)
    );

endmodule

// File: rtl/spi_csq_master_chk.sv
module spi_csq_master_chk #(
    parameter  int QDEPTH = 4,
    localparam int CW     = $clog2(QDEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic          eoq_clr_bit,
    input logic          sck,
    input logic [4:0]    cs_o,
    input logic          busy,
    input logic          push_req,
    input logic          tx_full,
    input logic [CW-1:0] tx_count,
    input logic          eoq_flag,
    input logic          ovf_flag
);

    // R10
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R3
    cs_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(cs_o));

    // R5
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(QDEPTH));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && tx_full) |=> ovf_flag);

    // R6
    eoq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoq_flag && !(reg_we && reg_addr == 2'd1 && eoq_clr_bit)) |=> eoq_flag);

endmodule

bind spi_csq_master spi_csq_master_chk #(.QDEPTH(QDEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .eoq_clr_bit (reg_wdata[16]),
    .sck         (sck),
    .cs_o        (cs_o),
    .busy        (busy),
    .push_req    (push_req),
    .tx_full     (tx_full),
    .tx_count    (tx_count),
    .eoq_flag    (eoq_flag),
    .ovf_flag    (ovf_flag)
);

// File: tb/spi_csq_master_test.sv
module spi_csq_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        sck;
    logic        mosi;
    logic        miso;
    logic [4:0]  cs_o;

    always #4 clk = ~clk;

    spi_csq_master uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .cs_o      (cs_o)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    logic [7:0] exp_mosi[$];
    logic [4:0] exp_cs[$];
    logic [7:0] exp_rx[$];
    int         drv_k = 0;
    logic [4:0] cur_idle = 5'h1F;

    function automatic logic [7:0] resp_of(input int k);
        return 8'(k * 53 + 90);
    endfunction

    function automatic logic [31:0] push_word(input logic [7:0] d, input logic [4:0] s,
                                              input bit cont, input bit eoq);
        logic [31:0] w = 32'd0;
        w[7:0]   = d;
        w[20:16] = s;
        w[30]    = cont;
        w[29]    = eoq;
        return w;
    endfunction

    function automatic logic [31:0] ctrl_word(input bit en, input logic [7:0] dv,
                                              input logic [4:0] idl, input bit ftx, input bit frx);
        logic [31:0] w = 32'd0;
        w[0]     = en;
        w[1]     = ftx;
        w[2]     = frx;
        w[15:8]  = dv;
        w[20:16] = idl;
        return w;
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    // driver: queue the expectation, then push the command
    task automatic send(input logic [7:0] d, input logic [4:0] s, input bit cont, input bit eoq);
        exp_mosi.push_back(d);
        exp_cs.push_back(cur_idle ^ s);
        exp_rx.push_back(resp_of(drv_k));
        drv_k++;
        wr(2'd2, push_word(d, s, cont, eoq));
    endtask

    task automatic wait_rx(input int n, input string tag);
        logic [31:0] st;
        for (int i = 0; i < 400; i++) begin
            rd(2'd1, st);
            if (int'(st[7:4]) == n) return;
        end
        check_eq(tag, {28'd0, st[7:4]}, n);
    endtask

    task automatic pop_check(input string tag);
        logic [31:0] v;
        logic [7:0]  e;
        rd(2'd3, v);
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'h00;
        check_eq(tag, v, {24'd0, e});
    endtask

    // slave model and monitor
    logic [7:0] rsp = 8'h00;
    logic [7:0] rxb = 8'h00;
    int         bitc = 0;
    int         sk = 0;
    bit         reload = 1'b0;
    time        t_prev = 0;
    time        last_period = 0;

    assign miso = rsp[7];
    initial rsp = resp_of(0);

    always @(posedge sck) begin
        if (rst_n) begin
            if (bitc > 0) last_period = $time - t_prev;
            t_prev = $time;
            rxb = {rxb[6:0], mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                reload = 1'b1;
                if (exp_mosi.size() == 0) begin
                    check_eq("R2 unexpected frame", {24'd0, rxb}, 32'hFFFF_FFFF);
                end else begin
                    check_eq("R2 mosi byte", {24'd0, rxb}, {24'd0, exp_mosi.pop_front()});
                    check_eq("R3 cs pattern", {27'd0, cs_o}, {27'd0, exp_cs.pop_front()});
                end
            end
        end
    end

    always @(negedge sck) begin
        if (rst_n) begin
            if (reload) begin
                reload = 1'b0;
                sk++;
                rsp = resp_of(sk);
            end else begin
                rsp = {rsp[6:0], 1'b0};
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_eq("R1 cs idle", {27'd0, cs_o}, 32'h1F);
        check_eq("R1 sck low", {31'd0, sck}, 32'd0);
        rd(2'd1, v); check_eq("R1 status", v, 32'd0);
        rd(2'd0, v); check_eq("R1 control", v, 32'h001F_0300);

        // R2 R3 R7 R10: three frames, one of them continued
        wr(2'd0, ctrl_word(1'b1, 8'd1, 5'h1F, 1'b0, 1'b0));
        send(8'hA5, 5'h01, 1'b0, 1'b0);
        send(8'h3C, 5'h0A, 1'b1, 1'b0);
        send(8'hF0, 5'h0A, 1'b0, 1'b1);
        wait_rx(3, "R7 rx count after three frames");
        check_eq("R10 sck period div1", 32'(last_period), 32'd32);
        repeat (3) @(negedge clk);
        check_eq("R4 cs released", {27'd0, cs_o}, 32'h1F);
        rd(2'd1, v);
        check_eq("R6 eoq set", {31'd0, v[16]}, 32'd1);
        check_eq("R4 busy clear", {31'd0, v[0]}, 32'd0);
        pop_check("R7 rx byte 0");
        pop_check("R7 rx byte 1");
        pop_check("R7 rx byte 2");
        rd(2'd1, v); check_eq("R7 rx empty", {28'd0, v[7:4]}, 32'd0);

        // R6 clear by writing 1
        wr(2'd1, 32'h0001_0000);
        rd(2'd1, v); check_eq("R6 eoq cleared", {31'd0, v[16]}, 32'd0);

        // R4 continue holds chip select
        send(8'h5A, 5'h1C, 1'b1, 1'b0);
        wait_rx(1, "R4 first frame done");
        repeat (10) @(negedge clk);
        check_eq("R4 cs held", {27'd0, cs_o}, {27'd0, 5'h1F ^ 5'h1C});
        rd(2'd1, v); check_eq("R4 busy held", {31'd0, v[0]}, 32'd1);
        send(8'hC3, 5'h1C, 1'b0, 1'b0);
        wait_rx(2, "R4 second frame done");
        repeat (3) @(negedge clk);
        check_eq("R4 cs released after final", {27'd0, cs_o}, 32'h1F);
        pop_check("R4 rx byte 0");
        pop_check("R4 rx byte 1");

        // R5 R11 R8: full queue while disabled, overflow, flush
        wr(2'd0, ctrl_word(1'b0, 8'd1, 5'h1F, 1'b0, 1'b0));
        for (int i = 0; i < 4; i++) wr(2'd2, push_word(8'(i), 5'h01, 1'b0, 1'b0));
        rd(2'd1, v);
        check_eq("R5 tx count full", {28'd0, v[15:12]}, 32'd4);
        check_eq("R5 no overflow yet", {31'd0, v[17]}, 32'd0);
        repeat (20) @(negedge clk);
        check_eq("R11 sck idle while disabled", {31'd0, sck}, 32'd0);
        wr(2'd2, push_word(8'hEE, 5'h01, 1'b0, 1'b0));
        rd(2'd1, v);
        check_eq("R5 count unchanged", {28'd0, v[15:12]}, 32'd4);
        check_eq("R5 overflow set", {31'd0, v[17]}, 32'd1);
        wr(2'd0, ctrl_word(1'b0, 8'd1, 5'h1F, 1'b1, 1'b0));
        rd(2'd1, v); check_eq("R8 tx flushed", {28'd0, v[15:12]}, 32'd0);
        rd(2'd0, v); check_eq("R8 strobes read zero", {29'd0, v[2:0]}, 32'd0);
        wr(2'd1, 32'h0002_0000);
        rd(2'd1, v); check_eq("R5 overflow cleared", {31'd0, v[17]}, 32'd0);

        // R9 R10: new inactive levels and slower clock
        cur_idle = 5'h15;
        wr(2'd0, ctrl_word(1'b1, 8'd3, 5'h15, 1'b0, 1'b0));
        check_eq("R9 idle levels", {27'd0, cs_o}, 32'h15);
        send(8'h96, 5'h03, 1'b0, 1'b0);
        wait_rx(1, "R9 frame done");
        check_eq("R10 sck period div3", 32'(last_period), 32'd64);
        pop_check("R9 rx byte");

        // R8 receive flush
        send(8'h11, 5'h1F, 1'b0, 1'b0);
        wait_rx(1, "R8 frame done");
        wr(2'd0, ctrl_word(1'b1, 8'd3, 5'h15, 1'b0, 1'b1));
        exp_rx.delete();
        rd(2'd1, v); check_eq("R8 rx flushed", {28'd0, v[7:4]}, 32'd0);
        check_eq("R2 all frames seen", 32'(exp_mosi.size()), 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule